// File: doc/BRIEF.md
# Serial Receive Deserialiser with Line Status

This block turns an asynchronous serial line into bytes. A free-running enable pulse at sixteen times the bit rate paces it; on every such pulse it looks at the line. The framing settings are shared with the matching transmitter: a word length of 5 to 8 bits and an optional parity bit. A completed word goes into a single holding buffer. A set of status flags reports whether a word is waiting, whether one was lost, and whether the last words arrived with a bad parity bit, a bad stop bit or as a break.

The host reads the buffer and the status through two one-cycle read strobes, and each read clears the flags that belong to it. A loopback select routes the transmitter's serial output into the receiver in place of the pin, so both halves can be tested on chip without outside wiring.

Top module: `serial_rx_unit`

## Requirements
- R1: After a synchronous reset, `line_status` is 8'h00 and `rx_byte` is 8'h00.
- R2: A frame has a 0 start bit, then `5 + word_len` data bits least significant first, an optional parity bit and a stop bit. When a frame completes into an empty buffer, its data appears right-aligned in `rx_byte` with the unused upper bits 0, and `line_status` bit 0 (word waiting) sets.
- R3: `par_cfg` is {stick, even, enable}. With enable at 0 there is no parity bit. The codes 001 and 011 expect odd and even parity over the data bits. The codes 101 and 111 expect a constant 1 and a constant 0. A mismatch sets `line_status` bit 2.
- R4: A stop bit sampled as 0 sets `line_status` bit 3. Only one stop bit is checked, so a new start bit may follow the first stop bit directly.
- R5: A frame that completes while bit 0 is still set and `rd_data` is not asserted sets `line_status` bit 1. The new word and its error flags are dropped, and `rx_byte` keeps the older word.
- R6: A frame that is 0 from its start bit to its stop bit is a break. It sets bit 4 and loads 8'h00 with bit 0, and it sets neither bit 2 nor bit 3. No new frame starts until the line has returned to 1.
- R7: `line_status` bit 7 is 1 exactly while any of bits 2, 3 or 4 is 1.
- R8: `rd_data` clears bit 0 and `rd_status` clears bits 1 to 4 and bit 7. A flag set by a frame completing in the same cycle as the strobe stays set.
- R9: A low pulse on the line that is back at 1 when checked half a bit after the falling edge starts no frame.
- R10: With `loop_en` at 1 the receiver takes `tx_loop` and ignores `rx_pin`.
- R11: `line_status` bits 5 and 6 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_pin | input | 1 | Serial line from the pin, idle 1 |
| loop_en | input | 1 | Take `tx_loop` instead of `rx_pin` |
| tx_loop | input | 1 | Transmitter serial output for loopback |
| word_len | input | 2 | Data bits minus 5 |
| par_cfg | input | 3 | Parity mode {stick, even, enable} |
| rd_data | input | 1 | Host read of the receive buffer |
| rd_status | input | 1 | Host read of the status flags |
| rx_byte | output | 8 | Receive buffer |
| line_status | output | 8 | Status flags: bit 0 waiting, bit 1 lost, bit 2 parity, bit 3 stop, bit 4 break, bit 7 summary |

## Verification
The bench drives back-to-back frames whose second stop slot is already a new start bit. A receiver that checked a second stop bit would flag a false stop error there, and one that overwrote the buffer would lose the older word. It sends a long all-zero line to catch a receiver that re-triggers during a break. It sends a short low glitch that a receiver without the mid-start recheck would decode as a 0xFF-like word. It covers each parity code with both a matching and a wrong parity bit, where swapped odd and even or inverted sticky codes show up as flags on the wrong frames. It also holds the pin at 0 during loopback, which a receiver that leaked the pin would report as a break.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int RX_DW = 8;

  localparam int SB_READY = 0;
  localparam int SB_LOST  = 1;
  localparam int SB_PAR   = 2;
  localparam int SB_STOP  = 3;
  localparam int SB_BRK   = 4;
  localparam int SB_ANY   = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_BRKWAIT
  } rx_state_t;

  typedef struct packed {
    logic [RX_DW-1:0] data;
    logic             perr;
    logic             ferr;
    logic             brk;
  } rx_frame_t;
endpackage

// File: rtl/serial_rx_linesel.sv
module serial_rx_linesel (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  input  logic tx_loop,
  input  logic loop_en,
  output logic line_q
);
  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else     line_q <= loop_en ? tx_loop : rx_pin;
  end
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] word_len,
  input  logic [2:0] par_cfg,
  output logic       done,
  output rx_frame_t  frame
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(RX_DW);
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OSR - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [RX_DW-1:0] shreg;
  logic             par_bit;

  logic par_en, par_even, par_stick;
  assign par_en    = par_cfg[0];
  assign par_even  = par_cfg[1];
  assign par_stick = par_cfg[2];

  logic [IDX_W-1:0] last_idx;
  assign last_idx = IDX_W'(4) + IDX_W'(word_len);

  logic exp_par, all_space;
  always_comb begin
    if (par_stick)     exp_par = ~par_even;
    else if (par_even) exp_par = ^shreg;
    else               exp_par = ~^shreg;
    all_space = (shreg == '0) && !(par_en && par_bit) && !line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      frame   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: if (!line) begin
            state <= ST_START;
            cnt   <= '0;
          end
          ST_START: begin
            if (cnt == CNT_MID) begin
              cnt   <= '0;
              idx   <= '0;
              shreg <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == CNT_END) begin
              cnt        <= '0;
              shreg[idx] <= line;
              if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
              else                 idx   <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == CNT_END) begin
              cnt     <= '0;
              par_bit <= line;
              state   <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (cnt == CNT_END) begin
              cnt        <= '0;
              done       <= 1'b1;
              frame.data <= shreg;
              frame.brk  <= all_space;
              frame.ferr <= !line && !all_space;
              frame.perr <= par_en && !all_space && (par_bit != exp_par);
              state      <= all_space ? ST_BRKWAIT : ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_BRKWAIT: if (line) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import serial_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  rx_frame_t        frame,
  input  logic             rd_data,
  input  logic             rd_status,
  output logic [RX_DW-1:0] buf_q,
  output logic [7:0]       status
);
  logic ready, lost, perr, ferr, brk, any_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      {ready, lost, perr, ferr, brk, any_err} <= '0;
    end else begin
      if (rd_data)   ready <= 1'b0;
      if (rd_status) {lost, perr, ferr, brk, any_err} <= '0;
      if (done) begin
        if (ready && !rd_data) begin
          lost <= 1'b1;
        end else begin
          buf_q <= frame.data;
          ready <= 1'b1;
          if (frame.perr) perr <= 1'b1;
          if (frame.ferr) ferr <= 1'b1;
          if (frame.brk)  brk  <= 1'b1;
          if (frame.perr || frame.ferr || frame.brk) any_err <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    status           = '0;
    status[SB_READY] = ready;
    status[SB_LOST]  = lost;
    status[SB_PAR]   = perr;
    status[SB_STOP]  = ferr;
    status[SB_BRK]   = brk;
    status[SB_ANY]   = any_err;
  end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rx_pin,
  input  logic       loop_en,
  input  logic       tx_loop,
  input  logic [1:0] word_len,
  input  logic [2:0] par_cfg,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_byte,
  output logic [7:0] line_status
);
  logic      line_q;
  logic      frame_done;
  rx_frame_t frame;

  serial_rx_linesel i_sel (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .tx_loop(tx_loop),
    .loop_en(loop_en), .line_q(line_q)
  );

  serial_rx_framer #(.OSR(OSR)) i_framer (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_q),
    .word_len(word_len), .par_cfg(par_cfg),
    .done(frame_done), .frame(frame)
  );

  serial_rx_status i_stat (
    .clk(clk), .rst(rst), .done(frame_done), .frame(frame),
    .rd_data(rd_data), .rd_status(rd_status),
    .buf_q(rx_byte), .status(line_status)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk,
  input logic       rst,
  input logic       rd_data,
  input logic       rd_status,
  input logic       frame_done,
  input logic [7:0] rx_byte,
  input logic [7:0] line_status
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (line_status == 8'h00)); // R1

  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> line_status[0]); // R2

  AST_LOST_KEEPS_BUF: assert property (@(posedge clk) disable iff (rst)
    (frame_done && line_status[0] && !rd_data) |=> (line_status[1] && $stable(rx_byte))); // R5

  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
    line_status[7] == (|line_status[4:2])); // R7

  AST_DATA_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !frame_done) |=> !line_status[0]); // R8

  AST_STATUS_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !frame_done) |=> (line_status[4:1] == 4'b0 && !line_status[7])); // R8
endmodule

bind serial_rx_unit serial_rx_checker i_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .rd_status(rd_status),
  .frame_done(frame_done), .rx_byte(rx_byte), .line_status(line_status)
);

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_pin = 1'b1;
  logic       loop_en = 1'b0;
  logic       tx_loop = 1'b1;
  logic [1:0] word_len = 2'b11;
  logic [2:0] par_cfg = 3'b000;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_byte;
  logic [7:0] line_status;

  int n_chk = 0;
  int n_fail = 0;
  bit to_loop = 1'b0;
  localparam int BIT_CLKS = 32;

  always #5 clk = ~clk;

  serial_rx_unit i_serial_rx_unit (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_pin(rx_pin),
    .loop_en(loop_en), .tx_loop(tx_loop), .word_len(word_len),
    .par_cfg(par_cfg), .rd_data(rd_data), .rd_status(rd_status),
    .rx_byte(rx_byte), .line_status(line_status)
  );

  always @(negedge clk) tick16 = rst ? 1'b0 : ~tick16;

  // behavioural reference model
  int         m_st, m_cnt, m_idx;
  logic [7:0] m_sh, m_buf, m_fd;
  logic       m_pb, m_line, m_done, m_fpe, m_ffe, m_fbi;
  logic       m_dr, m_oe, m_pe, m_fe, m_bi, m_err;

  function automatic logic want_parity(input logic [7:0] d, input int nb, input logic [2:0] cfg);
    int ones = 0;
    for (int i = 0; i < nb; i++) if (d[i]) ones++;
    if (cfg[2]) return !cfg[1];
    if (cfg[1]) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_idx = 0; m_sh = 0; m_pb = 0; m_line = 1;
      m_done = 0; m_fd = 0; m_fpe = 0; m_ffe = 0; m_fbi = 0; m_buf = 0;
      {m_dr, m_oe, m_pe, m_fe, m_bi, m_err} = '0;
    end else begin
      logic old_dr;
      int nb;
      old_dr = m_dr;
      nb = 5 + int'(word_len);
      if (rd_data) m_dr = 0;
      if (rd_status) {m_oe, m_pe, m_fe, m_bi, m_err} = '0;
      if (m_done) begin
        if (old_dr && !rd_data) m_oe = 1;
        else begin
          m_buf = m_fd; m_dr = 1;
          m_pe |= m_fpe; m_fe |= m_ffe; m_bi |= m_fbi;
          m_err |= (m_fpe | m_ffe | m_fbi);
        end
      end
      m_done = 0;
      if (tick16) begin
        m_cnt++;
        if (m_st == 0) begin
          if (!m_line) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
          if (m_cnt == 8) begin
            m_st = m_line ? 0 : 2; m_cnt = 0; m_idx = 0; m_sh = 0;
          end
        end else if (m_st == 2) begin
          if (m_cnt == 16) begin
            m_cnt = 0; m_sh[m_idx] = m_line; m_idx++;
            if (m_idx == nb) m_st = par_cfg[0] ? 3 : 4;
          end
        end else if (m_st == 3) begin
          if (m_cnt == 16) begin m_cnt = 0; m_pb = m_line; m_st = 4; end
        end else if (m_st == 4) begin
          if (m_cnt == 16) begin
            m_cnt = 0; m_done = 1; m_fd = m_sh;
            m_fbi = (m_sh == 0) && !(par_cfg[0] && m_pb) && !m_line;
            m_ffe = !m_line && !m_fbi;
            m_fpe = par_cfg[0] && !m_fbi && (m_pb != want_parity(m_sh, nb, par_cfg));
            m_st = m_fbi ? 5 : 0;
          end
        end else begin
          if (m_line) m_st = 0;
        end
      end
      m_line = loop_en ? tx_loop : rx_pin;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (rx_byte !== m_buf ||
          line_status !== {m_err, 2'b00, m_bi, m_fe, m_pe, m_oe, m_dr}) begin
        n_fail++;
        $display("FAIL per-cycle model (R2 R5 R6 R8 R9): actual byte=%h st=%h expected byte=%h st=%h",
                 rx_byte, line_status, m_buf, {m_err, 2'b00, m_bi, m_fe, m_pe, m_oe, m_dr});
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic v, input int n);
    if (to_loop) tx_loop = v; else rx_pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop_v, input int stop_clks);
    int nb;
    nb = 5 + int'(word_len);
    put_bit(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) put_bit(d[i], BIT_CLKS);
    if (par_cfg[0]) put_bit(want_parity(d, nb, par_cfg), BIT_CLKS);
    put_bit(stop_v, stop_clks);
  endtask

  task automatic send_badpar(input logic [7:0] d);
    int nb;
    nb = 5 + int'(word_len);
    put_bit(1'b0, BIT_CLKS);
    for (int i = 0; i < nb; i++) put_bit(d[i], BIT_CLKS);
    put_bit(!want_parity(d, nb, par_cfg), BIT_CLKS);
    put_bit(1'b1, BIT_CLKS);
  endtask

  task automatic idle(input int bits);
    put_bit(1'b1, bits * BIT_CLKS);
  endtask

  task automatic read_both();
    rd_data = 1'b1; rd_status = 1'b1;
    @(negedge clk);
    rd_data = 1'b0; rd_status = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset status", line_status, 8'h00);
    chk("R1 reset buffer", rx_byte, 8'h00);
    idle(2);

    // R2: 8-bit word
    send(8'hA5, 1'b1, BIT_CLKS); idle(2);
    chk("R2 8-bit data", rx_byte, 8'hA5);
    chk("R2 ready set", line_status, 8'h01);
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
    chk("R8 data read clears ready", line_status, 8'h00);

    // R2: 5-bit word, upper bits zero
    word_len = 2'b00;
    send(8'hF5, 1'b1, BIT_CLKS); idle(2);
    chk("R2 5-bit right aligned", rx_byte, 8'h15);
    read_both();

    // R3: parity modes, 7-bit words
    word_len = 2'b10;
    par_cfg = 3'b001; send(8'h5A, 1'b1, BIT_CLKS); idle(2);
    chk("R3 odd parity good", line_status, 8'h01); read_both();
    send_badpar(8'h5A); idle(2);
    chk("R3 odd parity bad", line_status, 8'h85);
    chk("R7 summary on parity", line_status[7], 1'b1);
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
    chk("R8 status read clears errors", line_status, 8'h01);
    read_both();
    par_cfg = 3'b011; send(8'h33, 1'b1, BIT_CLKS); idle(2);
    chk("R3 even parity good", line_status, 8'h01); read_both();
    send_badpar(8'h33); idle(2);
    chk("R3 even parity bad", line_status, 8'h85); read_both();
    par_cfg = 3'b101; send(8'h00, 1'b1, BIT_CLKS); idle(2);
    chk("R3 stick high good", line_status, 8'h01); read_both();
    par_cfg = 3'b111; send(8'h7F, 1'b1, BIT_CLKS); idle(2);
    chk("R3 stick low good", line_status, 8'h01); read_both();
    send_badpar(8'h7F); idle(2);
    chk("R3 stick low bad", line_status, 8'h85); read_both();

    // R4: bad stop bit
    word_len = 2'b11; par_cfg = 3'b000;
    send(8'h81, 1'b0, 20); idle(3);
    chk("R4 stop error", line_status, 8'h89);
    chk("R4 data kept", rx_byte, 8'h81);
    read_both();

    // R4 + R5: back-to-back frames, second lost
    send(8'h3C, 1'b1, BIT_CLKS);
    send(8'hC3, 1'b1, BIT_CLKS); idle(2);
    chk("R4 R5 lost flag only", line_status, 8'h03);
    chk("R5 older word kept", rx_byte, 8'h3C);
    read_both();
    chk("R8 all cleared", line_status, 8'h00);

    // R6: break
    put_bit(1'b0, 24 * BIT_CLKS);
    chk("R6 break flags", line_status, 8'h91);
    chk("R6 break byte", rx_byte, 8'h00);
    idle(2);
    chk("R6 no frame during break", line_status, 8'h91);
    read_both();
    send(8'h5E, 1'b1, BIT_CLKS); idle(2);
    chk("R6 receive after break", rx_byte, 8'h5E);
    read_both();

    // R9: glitch
    put_bit(1'b0, 8); idle(3);
    chk("R9 glitch ignored", line_status, 8'h00);
    send(8'h96, 1'b1, BIT_CLKS); idle(2);
    chk("R9 frame after glitch", rx_byte, 8'h96);
    read_both();

    // R10: loopback, pin held low
    loop_en = 1'b1; rx_pin = 1'b0; to_loop = 1'b1;
    idle(2);
    send(8'h4B, 1'b1, BIT_CLKS); idle(2);
    chk("R10 loopback data", rx_byte, 8'h4B);
    chk("R10 pin ignored", line_status, 8'h01);
    chk("R11 spare bits zero", {6'b0, line_status[6:5]}, 8'h00);
    read_both();
    loop_en = 1'b0; rx_pin = 1'b1; to_loop = 1'b0;
    idle(2);

    finish_run();
  end
endmodule